// File: doc/BRIEF.md
# Scan-Window Conversion Sequencer

This block decides when an ADC may start a conversion. Two pacing inputs feed it: a scan clock and a conversion clock. A rising scan clock edge opens an acquisition window. Each conversion clock edge that arrives while the window is open becomes a one-cycle convert strobe. The window closes once it has issued as many strobes as the programmed channel count. Alongside each strobe the block drives a channel index, which the input multiplexer uses to pick the channel to convert.

Both pacing inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer and is then edge-detected in the system clock domain. A single-source mode bit makes the conversion clock act as the scan clock as well, so one pacing signal can drive continuous acquisition. The block moves no data stream, so all of its pins are plain control and status signals, with no valid/ready handshake.

Top module: `scan_conv_seq`

## Requirements
- R1: When enable is high, single_src is low, the window is closed and chan_count is non-zero, a rising edge on scan_clk_in opens the window. window_active is high by the third rising clk edge after the input rises.
- R2: Each rising edge of conv_clk_in that arrives while the window is open produces exactly one conv_strobe pulse, one clk cycle wide. In dual-clock mode, a conversion edge that arrives while the window is closed produces no strobe.
- R3: Once the window has issued chan_count strobes, window_active goes low. Further conversion edges produce no strobe until a new window opens.
- R4: chan_idx is 0 when a window opens. It increases by one after each strobe that leaves the window open. While conv_strobe is high, chan_idx holds the number of the channel being converted, so strobe k of a window shows index k, counting from 0.
- R5: In dual-clock mode, a scan edge that arrives while the window is open sets overrun. Such an edge does not restart the window or reset chan_idx. overrun then stays high until enable goes low.
- R6: When single_src is high, scan_clk_in is ignored. A conversion edge that arrives while the window is closed opens a window and is itself converted as channel 0. Edges that follow are converted until chan_count is reached. overrun never sets in this mode.
- R7: While enable is low, the window is closed, overrun is cleared, chan_idx is 0 and no strobe is issued, whatever the pacing inputs do.
- R8: A chan_count of zero never opens a window, so no strobe is produced.
- R9: After reset, conv_strobe, window_active, overrun and chan_idx are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_clk_in | input | 1 | Asynchronous scan pacing input |
| conv_clk_in | input | 1 | Asynchronous conversion pacing input |
| enable | input | 1 | Run enable; low clears the window and overrun |
| chan_count | input | CH_W (4) | Number of conversions per window |
| single_src | input | 1 | 1: the conversion clock also acts as the scan clock |
| conv_strobe | output | 1 | One-cycle ADC start pulse |
| chan_idx | output | CH_W (4) | Multiplexer channel for the current conversion |
| window_active | output | 1 | Acquisition window is open |
| overrun | output | 1 | Sticky: a scan edge arrived during an open window |

## Verification
The bench goes after the edges of a window. It checks that conversion edges beyond the channel count are dropped. A design that compared the count off by one would issue one strobe too many or too few. It checks that a second scan edge inside an open window only raises overrun. A design that restarted the window on that edge would send chan_idx back to 0 and issue extra strobes. In single-source mode it checks that the edge which opens a window is also converted, and that scan_clk_in has no effect. It also checks that a zero channel count, and conversion edges with no scan edge before them, both yield no strobe at all.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_t;
endpackage

// File: rtl/scs_edge_sync.sv
module scs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], async_in};
  end

  // pipe_q[STAGES-1] is the last synchronizer flop; pipe_q[STAGES] is its delayed copy.
  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/scs_window_ctrl.sv
module scs_window_ctrl
  import scs_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            single_src,
  input  logic [CH_W-1:0] chan_count,
  input  logic            scan_rise,
  input  logic            conv_rise,
  output logic            open_evt,
  output logic            strobe,
  output logic            win_open,
  output logic            overrun
);
  win_state_t      state_q;
  logic [CH_W-1:0] done_q;
  logic [CH_W-1:0] done_base;
  logic [CH_W-1:0] done_next;
  logic            opener;
  logic            accept;
  logic            last;

  assign opener    = single_src ? conv_rise : scan_rise;
  assign open_evt  = enable && (chan_count != '0) && (state_q == WIN_IDLE) && opener;
  assign accept    = enable && (((state_q == WIN_OPEN) && conv_rise) || (single_src && open_evt));
  assign done_base = open_evt ? '0 : done_q;
  assign done_next = done_base + 1'b1;
  assign last      = accept && (done_next == chan_count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      done_q  <= '0;
      strobe  <= 1'b0;
      overrun <= 1'b0;
    end else if (!enable) begin
      state_q <= WIN_IDLE;
      done_q  <= '0;
      strobe  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      strobe <= accept;
      if (accept) done_q <= done_next;
      else if (open_evt) done_q <= '0;
      if (last) state_q <= WIN_IDLE;
      else if (open_evt) state_q <= WIN_OPEN;
      if (!single_src && scan_rise && (state_q == WIN_OPEN)) overrun <= 1'b1;
    end
  end

  assign win_open = (state_q == WIN_OPEN);
endmodule

// File: rtl/scs_chan_index.sv
module scs_chan_index #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            open_evt,
  input  logic            strobe,
  input  logic            win_open,
  output logic [CH_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  idx <= '0;
    else if (!enable)            idx <= '0;
    else if (open_evt)           idx <= '0;
    else if (strobe && win_open) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/scan_conv_seq.sv
module scan_conv_seq #(
  parameter int CH_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_clk_in,
  input  logic            conv_clk_in,
  input  logic            enable,
  input  logic [CH_W-1:0] chan_count,
  input  logic            single_src,
  output logic            conv_strobe,
  output logic [CH_W-1:0] chan_idx,
  output logic            window_active,
  output logic            overrun
);
  localparam int NPACE = 2;

  logic [NPACE-1:0] pace_in;
  logic [NPACE-1:0] pace_rise;
  logic             open_evt;

  assign pace_in = {conv_clk_in, scan_clk_in};

  for (genvar g = 0; g < NPACE; g++) begin : g_sync
    scs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pace_in[g]),
      .rise     (pace_rise[g])
    );
  end

  scs_window_ctrl #(.CH_W(CH_W)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .single_src (single_src),
    .chan_count (chan_count),
    .scan_rise  (pace_rise[0]),
    .conv_rise  (pace_rise[1]),
    .open_evt   (open_evt),
    .strobe     (conv_strobe),
    .win_open   (window_active),
    .overrun    (overrun)
  );

  scs_chan_index #(.CH_W(CH_W)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .open_evt (open_evt),
    .strobe   (conv_strobe),
    .win_open (window_active),
    .idx      (chan_idx)
  );
endmodule

// File: rtl/scan_conv_seq_chk.sv
module scan_conv_seq_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            single_src,
  input logic [CH_W-1:0] chan_count,
  input logic            conv_strobe,
  input logic [CH_W-1:0] chan_idx,
  input logic            window_active,
  input logic            overrun
);
  // R2: in dual-clock mode a strobe needs a window open in the cycle before
  a_r2_strobe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && !single_src && $past(!single_src)) |-> $past(window_active));

  // R2: a strobe lasts exactly one cycle
  a_r2_strobe_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |=> !conv_strobe);

  // R4: a freshly opened window starts at channel 0
  a_r4_idx_zero_on_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_active) |-> (chan_idx == '0));

  // R5: overrun holds while enable stays high
  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(overrun) && $past(enable)) |-> overrun);

  // R7: disabled means idle on the next cycle
  a_r7_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!window_active && !conv_strobe && !overrun && (chan_idx == '0)));

  // R8: a window only opens on a non-zero count
  a_r8_no_open_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_active) |-> ($past(chan_count) != '0));
endmodule

bind scan_conv_seq scan_conv_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .single_src    (single_src),
  .chan_count    (chan_count),
  .conv_strobe   (conv_strobe),
  .chan_idx      (chan_idx),
  .window_active (window_active),
  .overrun       (overrun)
);

// File: tb/scan_conv_seq_tb_top.sv
module scan_conv_seq_tb_top;
  localparam int CH_W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            scan_clk_in = 1'b0;
  logic            conv_clk_in = 1'b0;
  logic            enable = 1'b0;
  logic [CH_W-1:0] chan_count = '0;
  logic            single_src = 1'b0;
  logic            conv_strobe;
  logic [CH_W-1:0] chan_idx;
  logic            window_active;
  logic            overrun;

  always #4 clk = ~clk;

  scan_conv_seq #(.CH_W(CH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_clk_in(scan_clk_in), .conv_clk_in(conv_clk_in),
    .enable(enable), .chan_count(chan_count), .single_src(single_src),
    .conv_strobe(conv_strobe), .chan_idx(chan_idx), .window_active(window_active),
    .overrun(overrun)
  );

  int total = 0;
  int bad = 0;
  int seen = 0;
  int idx_base = 0;
  int cur_cnt = 1;
  bit mon_on = 1'b0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic       single;
    logic [3:0] cnt;
    logic [3:0] nconv;
    logic [3:0] exp_str;
    logic       exp_win;
  } vec_t;

  // R2 R3 R4 R6 R8: mode, count, conversion pulses, expected strobes, window after
  localparam vec_t VECS [7] = '{
    '{1'b0, 4'd4, 4'd4, 4'd4, 1'b0},
    '{1'b0, 4'd3, 4'd6, 4'd3, 1'b0},
    '{1'b0, 4'd5, 4'd2, 4'd2, 1'b1},
    '{1'b0, 4'd1, 4'd1, 4'd1, 1'b0},
    '{1'b1, 4'd3, 4'd3, 4'd3, 1'b0},
    '{1'b1, 4'd2, 4'd5, 4'd5, 1'b1},
    '{1'b0, 4'd0, 4'd3, 4'd0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4: every strobe shows the channel given by its position in the window
  always @(negedge clk) begin
    if (mon_on && conv_strobe) begin
      check(chan_idx == (idx_base + seen) % cur_cnt, "R4 chan_idx at strobe",
            chan_idx, (idx_base + seen) % cur_cnt);
      seen++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_scan();
    @(negedge clk); scan_clk_in = 1'b1; wait_clks(3);
    scan_clk_in = 1'b0; wait_clks(3);
  endtask

  task automatic pulse_conv();
    @(negedge clk); conv_clk_in = 1'b1; wait_clks(3);
    conv_clk_in = 1'b0; wait_clks(3);
  endtask

  task automatic restart(input bit s, input int c);
    enable = 1'b0; wait_clks(2);
    single_src = s; chan_count = c[CH_W-1:0];
    enable = 1'b1; seen = 0; idx_base = 0; cur_cnt = (c == 0) ? 1 : c;
    wait_clks(1);
  endtask

  initial begin
    // R9: reset state
    wait_clks(3);
    check(!conv_strobe && !window_active && !overrun && chan_idx == 0, "R9 reset state",
          {conv_strobe, window_active, overrun}, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    for (int v = 0; v < 7; v++) begin
      restart(VECS[v].single, VECS[v].cnt);
      if (!VECS[v].single) begin
        pulse_scan();
        check(window_active == (VECS[v].cnt != 0), "R1 R8 window opens on scan",
              window_active, VECS[v].cnt != 0);
      end
      for (int p = 0; p < VECS[v].nconv; p++) pulse_conv();
      check(seen == VECS[v].exp_str, "R2 R3 R6 R8 strobe count", seen, VECS[v].exp_str);
      check(window_active == VECS[v].exp_win, "R3 window after pulses",
            window_active, VECS[v].exp_win);
      check(!overrun, "R5 no overrun without second scan", overrun, 0);
    end

    // R2: conversions without a scan edge in dual mode give nothing
    restart(1'b0, 3);
    pulse_conv(); pulse_conv();
    check(seen == 0 && !window_active, "R2 no strobe while closed", seen, 0);

    // R5: second scan inside window sets overrun, does not restart
    restart(1'b0, 3);
    pulse_scan(); pulse_conv();
    pulse_scan();
    check(overrun == 1'b1, "R5 overrun set", overrun, 1);
    check(window_active && chan_idx == 1, "R5 window not restarted", chan_idx, 1);
    pulse_conv(); pulse_conv();
    check(seen == 3 && !window_active, "R5 R3 window ends after count", seen, 3);
    pulse_conv();
    check(seen == 3, "R3 extra conversion ignored", seen, 3);
    check(overrun == 1'b1, "R5 overrun sticky", overrun, 1);

    // R7: enable low clears overrun and blocks everything
    enable = 1'b0; wait_clks(2);
    check(!overrun && !window_active && chan_idx == 0, "R7 disable clears",
          {overrun, window_active}, 0);
    pulse_scan(); pulse_conv();
    check(seen == 3 && !window_active, "R7 pulses ignored while disabled", seen, 3);

    // R6: scan input ignored in single-source mode
    restart(1'b1, 2);
    pulse_scan(); pulse_scan();
    check(seen == 0 && !window_active && !overrun, "R6 scan ignored in single mode",
          seen, 0);
    pulse_conv();
    check(seen == 1 && window_active && chan_idx == 1, "R6 opener converted as channel 0",
          chan_idx, 1);

    mon_on = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule